// File: doc/BRIEF.md
# Sized-Access System Bus Router

This block sits behind a CPU load/store unit. It takes one access at a time: a 32-bit address, a 3-bit size-and-sign code, a direction, write data and a debug qualifier. It trims the address to 27 bits and clears the low bits that the access width does not use. It then picks one of eight 16 MB windows from address bits 26:24 and sends the access to that window's target.

Three windows belong to memories held inside the block: a work RAM and a cartridge RAM, plus a cartridge ROM that can be written only under debug. Each memory is built as four byte lanes, so block RAM can be inferred. Its size is a power-of-two parameter, and the memory mirrors across its whole window. The cartridge memories can also be left out by parameter.

Three windows go to outside agents over a shared request/acknowledge port: video, sound and miscellaneous I/O. The remaining windows are empty. Read data goes back right-justified and is sign- or zero-extended to 32 bits according to the access code.

Top module: `sized_bus_router`

## Requirements
- R1: Before decoding, the address is ANDed with 0x07FFFFFF for byte codes (0, 1), with 0x07FFFFFE for halfword codes (2, 3) and with 0x07FFFFFC for word code 4. Codes 5, 6 and 7 behave exactly as code 4.
- R2: The target is chosen from trimmed bits 26:24: 0 video, 1 sound, 2 misc I/O, 3 empty, 4 expansion (empty), 5 work RAM, 6 cartridge RAM, 7 cartridge ROM. Bits 31:27 of the incoming address have no effect.
- R3: Work RAM is indexed by the low WRAM_AW bits of the trimmed address only, so its contents repeat across the whole window.
- R4: Cartridge RAM and ROM are indexed by the low CRAM_AW / CROM_AW bits. When a memory is disabled by parameter, reads from it return 0 and writes to it are lost.
- R5: A write to the cartridge ROM window changes the ROM only when acc_debug is 1. Otherwise the write completes but the contents are unchanged.
- R6: Reads from windows 3, 4 and 1 (sound) return 0 and raise no port request. Writes to windows 3 and 4 complete with no effect and no port request.
- R7: Memories are little-endian: byte address n holds data bits 7:0 and n+3 holds bits 31:24 of a word. A byte write changes 1 byte, a halfword write 2 bytes and a word write 4 bytes; all other bytes keep their values.
- R8: Read data is extended by code: 0 sign-extends bits 7:0, 1 zero-extends bits 7:0, 2 sign-extends bits 15:0, 3 zero-extends bits 15:0, and 4 to 7 return all 32 bits. The same rule applies to data returned by a port.
- R9: An access that does not use a port is accepted whenever acc_busy is 0 and acc_valid is 1. It raises rsp_valid for exactly one cycle, in the cycle after acceptance. One such access can be accepted every cycle. rsp_rdata is 0 for every write.
- R10: Video accesses, misc I/O accesses and sound writes raise bit 0, 2 or 1 of prt_req, one bit only, in the cycle after acceptance. prt_addr, prt_type, prt_write and prt_wdata stay stable until the matching prt_ack bit is sampled; acks on other bits are ignored. acc_busy is 1 while the request is open. rsp_valid follows in the cycle after the ack, and prt_req drops at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address |
| acc_type | input | 3 | Size/sign code (R8) |
| acc_wdata | input | 32 | Right-justified write data |
| acc_debug | input | 1 | Debug qualifier enabling ROM writes |
| acc_busy | output | 1 | A port request is open; no access is accepted |
| rsp_valid | output | 1 | Completion strobe |
| rsp_rdata | output | 32 | Extended read data |
| prt_req | output | 3 | One-hot request: bit 0 video, 1 sound, 2 misc |
| prt_write | output | 1 | Direction of the port request |
| prt_addr | output | 32 | Trimmed, aligned address of the port request |
| prt_type | output | 3 | Access code of the port request |
| prt_wdata | output | 32 | Write data of the port request |
| prt_ack | input | 3 | Per-port completion |
| prt_rdata | input | 96 | Per-port read data, port k in bits 32k+31:32k |

## Verification
On every cycle, the assertions check the port handshake: the request is one-hot, it is held stable until its own ack arrives, it completes in the cycle after that ack, and busy agrees with an open request. They also check that a port address is trimmed and aligned, that a non-port access answers one cycle later, that byte sign extension is correct, and that reads from the empty windows return zero. Only the bench scenarios show the effects that depend on stored contents: byte-lane merging, little-endian order, mirroring, ROM write protection without debug and absent cartridge memories. These scenarios compare the design against a byte-level reference model on every clock.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    RG_VIDEO = 3'd0,
    RG_SOUND = 3'd1,
    RG_MISC  = 3'd2,
    RG_NONE  = 3'd3,
    RG_EXP   = 3'd4,
    RG_WRAM  = 3'd5,
    RG_CRAM  = 3'd6,
    RG_CROM  = 3'd7
  } region_t;

  localparam int NPORT = 3;

  // 0: byte, 1: halfword, 2: word (codes 4..7)
  function automatic logic [1:0] sbr_size(input logic [2:0] t);
    if (t <= 3'd1)      return 2'd0;
    else if (t <= 3'd3) return 2'd1;
    else                return 2'd2;
  endfunction

  function automatic logic [31:0] sbr_extend(input logic [31:0] raw,
                                             input logic [2:0]  t);
    case (t)
      3'd0:    return {{24{raw[7]}}, raw[7:0]};
      3'd1:    return {24'd0, raw[7:0]};
      3'd2:    return {{16{raw[15]}}, raw[15:0]};
      3'd3:    return {16'd0, raw[15:0]};
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
(
  input  logic [31:0] addr,
  input  logic [2:0]  typ,
  input  logic [31:0] wdata,
  output logic [31:0] aligned,
  output region_t     region,
  output logic [3:0]  be,
  output logic [31:0] lane_wdata
);

  logic [1:0]  size;
  logic [31:0] mask;

  always_comb begin
    size = sbr_size(typ);
    case (size)
      2'd0:    mask = 32'h07FF_FFFF;
      2'd1:    mask = 32'h07FF_FFFE;
      default: mask = 32'h07FF_FFFC;
    endcase
    aligned = addr & mask;
    region  = region_t'(aligned[26:24]);
    case (size)
      2'd0: begin
        be         = 4'b0001 << aligned[1:0];
        lane_wdata = {4{wdata[7:0]}};
      end
      2'd1: begin
        be         = 4'b0011 << {aligned[1], 1'b0};
        lane_wdata = {2{wdata[15:0]}};
      end
      default: begin
        be         = 4'b1111;
        lane_wdata = wdata;
      end
    endcase
  end

endmodule

// File: rtl/sbr_mem.sv
module sbr_mem #(
  parameter int AW = 10,
  parameter bit EN = 1'b1
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-3:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  localparam int DEPTH = 1 << (AW - 2);

  generate
    if (EN) begin : g_present
      for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] store [DEPTH];
        logic [7:0] q;
        always_ff @(posedge clk) begin
          if (en) begin
            if (we && be[g]) store[idx] <= wdata[8*g +: 8];
            q <= store[idx];
          end
        end
        assign rdata[8*g +: 8] = q;
      end
    end else begin : g_absent
      logic unused_inputs;
      assign unused_inputs = ^{clk, en, we, be, idx, wdata};
      assign rdata = '0;
    end
  endgenerate

endmodule

// File: rtl/sized_bus_router.sv
module sized_bus_router
  import sbr_pkg::*;
#(
  parameter int WRAM_AW = 10,
  parameter int CRAM_AW = 10,
  parameter int CROM_AW = 10,
  parameter bit CRAM_EN = 1'b1,
  parameter bit CROM_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [31:0]          acc_addr,
  input  logic [2:0]           acc_type,
  input  logic [31:0]          acc_wdata,
  input  logic                 acc_debug,
  output logic                 acc_busy,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NPORT-1:0]     prt_req,
  output logic                 prt_write,
  output logic [31:0]          prt_addr,
  output logic [2:0]           prt_type,
  output logic [31:0]          prt_wdata,
  input  logic [NPORT-1:0]     prt_ack,
  input  logic [NPORT*32-1:0]  prt_rdata
);

  localparam int PSW = $clog2(NPORT);

  logic [31:0] aligned, lane_wdata;
  region_t     region;
  logic [3:0]  be;

  sbr_decode u_dec (
    .addr(acc_addr), .typ(acc_type), .wdata(acc_wdata),
    .aligned(aligned), .region(region), .be(be), .lane_wdata(lane_wdata)
  );

  logic waiting;
  logic accept, to_port;
  assign accept   = acc_valid && !waiting;
  assign to_port  = (region == RG_VIDEO) || (region == RG_MISC) ||
                    ((region == RG_SOUND) && acc_write);
  assign acc_busy = waiting;

  logic [31:0] wram_rd, cram_rd, crom_rd;

  sbr_mem #(.AW(WRAM_AW), .EN(1'b1)) u_wram (
    .clk(clk), .en(accept && region == RG_WRAM), .we(acc_write), .be(be),
    .idx(aligned[WRAM_AW-1:2]), .wdata(lane_wdata), .rdata(wram_rd)
  );
  sbr_mem #(.AW(CRAM_AW), .EN(CRAM_EN)) u_cram (
    .clk(clk), .en(accept && region == RG_CRAM), .we(acc_write), .be(be),
    .idx(aligned[CRAM_AW-1:2]), .wdata(lane_wdata), .rdata(cram_rd)
  );
  sbr_mem #(.AW(CROM_AW), .EN(CROM_EN)) u_crom (
    .clk(clk), .en(accept && region == RG_CROM), .we(acc_write && acc_debug),
    .be(be), .idx(aligned[CROM_AW-1:2]), .wdata(lane_wdata), .rdata(crom_rd)
  );

  logic [31:0] prd [NPORT];
  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_unpack
      assign prd[g] = prt_rdata[32*g +: 32];
    end
  endgenerate

  logic [PSW-1:0] psel_q;
  region_t        rsp_region_q;
  logic [2:0]     rsp_type_q;
  logic [1:0]     rsp_off_q;
  logic           rsp_write_q;
  logic [31:0]    port_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting      <= 1'b0;
      prt_req      <= '0;
      prt_write    <= 1'b0;
      prt_addr     <= '0;
      prt_type     <= '0;
      prt_wdata    <= '0;
      psel_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_region_q <= RG_NONE;
      rsp_type_q   <= '0;
      rsp_off_q    <= '0;
      rsp_write_q  <= 1'b0;
      port_rd_q    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        rsp_region_q <= region;
        rsp_type_q   <= acc_type;
        rsp_off_q    <= aligned[1:0];
        rsp_write_q  <= acc_write;
        if (to_port) begin
          waiting   <= 1'b1;
          psel_q    <= PSW'(region[1:0]);
          prt_req   <= {{(NPORT-1){1'b0}}, 1'b1} << region[1:0];
          prt_write <= acc_write;
          prt_addr  <= aligned;
          prt_type  <= acc_type;
          prt_wdata <= acc_wdata;
        end else begin
          rsp_valid <= 1'b1;
        end
      end else if (waiting && ((prt_req & prt_ack) != '0)) begin
        waiting   <= 1'b0;
        prt_req   <= '0;
        rsp_valid <= 1'b1;
        port_rd_q <= prd[psel_q];
      end
    end
  end

  logic [31:0] raw_sel;
  always_comb begin
    case (rsp_region_q)
      RG_WRAM:          raw_sel = wram_rd >> {rsp_off_q, 3'b000};
      RG_CRAM:          raw_sel = cram_rd >> {rsp_off_q, 3'b000};
      RG_CROM:          raw_sel = crom_rd >> {rsp_off_q, 3'b000};
      RG_VIDEO, RG_MISC: raw_sel = port_rd_q;
      default:          raw_sel = '0;
    endcase
    rsp_rdata = rsp_write_q ? 32'd0 : sbr_extend(raw_sel, rsp_type_q);
  end

  // ---------------- assertions ----------------
  p_req_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prt_req));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (prt_req != '0 && (prt_req & prt_ack) == '0) |=>
      ($stable(prt_req) && $stable(prt_addr) && $stable(prt_wdata) &&
       $stable(prt_write) && $stable(prt_type)));

  p_ack_done_r10: assert property (@(posedge clk) disable iff (rst)
    ((prt_req & prt_ack) != '0) |=> (rsp_valid && prt_req == '0));

  p_busy_req_r10: assert property (@(posedge clk) disable iff (rst)
    acc_busy |-> (prt_req != '0));

  p_port_align_r1: assert property (@(posedge clk) disable iff (rst)
    (prt_req != '0) |-> (prt_addr[31:27] == 5'd0 &&
      (sbr_size(prt_type) == 2'd0 ||
       (sbr_size(prt_type) == 2'd1 && !prt_addr[0]) ||
       (sbr_size(prt_type) == 2'd2 && prt_addr[1:0] == 2'd0))));

  p_local_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && !to_port) |=> rsp_valid);

  p_sext_byte_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_write_q && rsp_type_q == 3'd0) |->
      (rsp_rdata[31:8] == {24{rsp_rdata[7]}}));

  p_void_read_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && !acc_write &&
     (region == RG_NONE || region == RG_EXP || region == RG_SOUND)) |=>
      (rsp_rdata == 32'd0 && prt_req == '0));

endmodule

// File: tb/tb_sized_bus_router.sv
module tb_sized_bus_router;

  localparam int WAW = 10;
  localparam int CAW = 10;
  localparam int RAW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_debug = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic [2:0]  acc_type = '0;
  logic [2:0]  prt_ack = '0;
  logic [95:0] prt_rdata = '0;

  logic        acc_busy, rsp_valid, prt_write;
  logic [31:0] rsp_rdata, prt_addr, prt_wdata;
  logic [2:0]  prt_req, prt_type;

  logic        nc_busy, nc_valid, nc_pwrite;
  logic [31:0] nc_rdata, nc_paddr, nc_pwdata;
  logic [2:0]  nc_preq, nc_ptype;

  always #5 clk = ~clk;

  sized_bus_router #(.WRAM_AW(WAW), .CRAM_AW(CAW), .CROM_AW(RAW)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_type(acc_type), .acc_wdata(acc_wdata),
    .acc_debug(acc_debug), .acc_busy(acc_busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .prt_req(prt_req), .prt_write(prt_write),
    .prt_addr(prt_addr), .prt_type(prt_type), .prt_wdata(prt_wdata),
    .prt_ack(prt_ack), .prt_rdata(prt_rdata));

  sized_bus_router #(.WRAM_AW(WAW), .CRAM_AW(CAW), .CROM_AW(RAW),
                     .CRAM_EN(1'b0), .CROM_EN(1'b0)) dut_nc (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_type(acc_type), .acc_wdata(acc_wdata),
    .acc_debug(acc_debug), .acc_busy(nc_busy), .rsp_valid(nc_valid),
    .rsp_rdata(nc_rdata), .prt_req(nc_preq), .prt_write(nc_pwrite),
    .prt_addr(nc_paddr), .prt_type(nc_ptype), .prt_wdata(nc_pwdata),
    .prt_ack(prt_ack), .prt_rdata(prt_rdata));

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int          at;
    logic [31:0] d;
    bit          nc_zero;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] wm[int];
  logic [7:0] cm[int];
  logic [7:0] rm[int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // per-clock comparison of the response channel against the model queue
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(0, "R9 unexpected response", rsp_rdata, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.at == cyc, {e.tag, " timing"}, cyc, e.at);
          chk(rsp_rdata === e.d, e.tag, rsp_rdata, e.d);
          chk(nc_valid && nc_rdata === (e.nc_zero ? 32'd0 : e.d),
              {e.tag, " R4 absent-memory copy"}, nc_rdata,
              e.nc_zero ? 32'd0 : e.d);
        end
      end else begin
        chk(!nc_valid, "R9 idle absent-memory copy", nc_valid, 0);
        if (q.size() > 0 && q[0].at <= cyc) begin
          exp_t e;
          e = q.pop_front();
          chk(0, {e.tag, " missing response"}, 0, 1);
        end
      end
    end
  end

  function automatic int sz_bytes(input logic [2:0] t);
    if (t <= 3'd1) return 1;
    if (t <= 3'd3) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] trim(input logic [31:0] a, input logic [2:0] t);
    logic [31:0] m;
    m = 32'h07FF_FFFF & ~(32'(sz_bytes(t)) - 32'd1);
    return a & m;
  endfunction

  function automatic logic [31:0] ext(input logic [31:0] r, input logic [2:0] t);
    int n;
    logic [31:0] v;
    n = sz_bytes(t);
    if (n == 4) return r;
    v = (n == 1) ? (r & 32'hFF) : (r & 32'hFFFF);
    if ((t == 3'd0 && r[7]) || (t == 3'd2 && r[15]))
      v = v | ((n == 1) ? 32'hFFFF_FF00 : 32'hFFFF_0000);
    return v;
  endfunction

  // reference access: updates model memories, returns expected read data
  function automatic logic [31:0] model(input bit w, input logic [31:0] a,
                                        input logic [2:0] t, input logic [31:0] wd,
                                        input bit dbg);
    logic [31:0] ta, raw;
    int n, rg, k;
    ta = trim(a, t);
    n  = sz_bytes(t);
    rg = int'(ta[26:24]);
    raw = 32'd0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = wd[8*i +: 8];
      case (rg)
        5: begin
          k = int'(ta + 32'(i)) & ((1 << WAW) - 1);
          if (w) wm[k] = b; else raw[8*i +: 8] = wm.exists(k) ? wm[k] : 8'hxx;
        end
        6: begin
          k = int'(ta + 32'(i)) & ((1 << CAW) - 1);
          if (w) cm[k] = b; else raw[8*i +: 8] = cm.exists(k) ? cm[k] : 8'hxx;
        end
        7: begin
          k = int'(ta + 32'(i)) & ((1 << RAW) - 1);
          if (w && dbg) rm[k] = b;
          else if (!w) raw[8*i +: 8] = rm.exists(k) ? rm[k] : 8'hxx;
        end
        default: ;
      endcase
    end
    return w ? 32'd0 : ext(raw, t);
  endfunction

  task automatic mem_acc(input bit w, input logic [31:0] a, input logic [2:0] t,
                         input logic [31:0] wd, input bit dbg, input string tag);
    exp_t e;
    int rg;
    rg = int'(trim(a, t) >> 24) & 7;
    e.at = cyc + 1;
    e.d = model(w, a, t, wd, dbg);
    e.nc_zero = (rg == 6 || rg == 7);
    e.tag = tag;
    q.push_back(e);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_type = t;
    acc_wdata = wd; acc_debug = dbg;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(prt_req == 3'b000, {tag, " no port request"}, 32'(prt_req), 0);
  endtask

  task automatic port_acc(input bit w, input logic [31:0] a, input logic [2:0] t,
                          input logic [31:0] wd, input int pi, input int dly,
                          input logic [31:0] raw, input string tag);
    exp_t e;
    e.at = cyc + 2 + dly;
    e.d = w ? 32'd0 : ext(raw, t);
    e.nc_zero = 0;
    e.tag = tag;
    q.push_back(e);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_type = t;
    acc_wdata = wd; acc_debug = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(prt_req == 3'(1 << pi), {tag, " R10 request bit"}, 32'(prt_req), 32'(1 << pi));
    chk(prt_addr == trim(a, t), {tag, " R1 port address"}, prt_addr, trim(a, t));
    chk(prt_write == w && prt_type == t, {tag, " R10 port fields"},
        {28'd0, prt_write, prt_type}, {28'd0, w, t});
    if (w) chk(prt_wdata == wd, {tag, " R10 port wdata"}, prt_wdata, wd);
    chk(acc_busy == 1'b1, {tag, " R10 busy"}, 32'(acc_busy), 1);
    for (int i = 0; i < dly; i++) begin
      prt_ack = 3'(1 << ((pi + 1) % 3));   // ack on a foreign port: ignored
      @(negedge clk);
      chk(prt_req == 3'(1 << pi), {tag, " R10 held, foreign ack ignored"},
          32'(prt_req), 32'(1 << pi));
    end
    prt_ack = 3'(1 << pi);
    prt_rdata = {3{32'hDEAD_0BAD}};
    prt_rdata[32*pi +: 32] = raw;
    @(negedge clk);
    prt_ack = 3'b000;
    chk(prt_req == 3'b000 && !acc_busy, {tag, " R10 release"},
        {28'd0, acc_busy, prt_req}, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!rsp_valid && !acc_busy && prt_req == 3'b000, "R9 reset state",
        {27'd0, rsp_valid, acc_busy, prt_req}, 0);

    // R7 / R9: word write, back-to-back reads of bytes and halves
    mem_acc(1, 32'h0500_0010, 3'd4, 32'h8899_AABB, 0, "R7 word write");
    mem_acc(0, 32'h0500_0010, 3'd4, 0, 0, "R7 word read");
    mem_acc(0, 32'h0500_0010, 3'd0, 0, 0, "R8 S8 byte0");
    mem_acc(0, 32'h0500_0010, 3'd1, 0, 0, "R8 U8 byte0");
    mem_acc(0, 32'h0500_0013, 3'd0, 0, 0, "R8 S8 byte3");
    mem_acc(0, 32'h0500_0011, 3'd1, 0, 0, "R7 U8 byte1");
    mem_acc(0, 32'h0500_0012, 3'd2, 0, 0, "R8 S16 upper");
    mem_acc(0, 32'h0500_0012, 3'd3, 0, 0, "R8 U16 upper");
    // R1 / R7: partial writes with misaligned addresses
    mem_acc(1, 32'h0500_0013, 3'd3, 32'hFFFF_1234, 0, "R1 half write trimmed");
    mem_acc(0, 32'h0500_0010, 3'd4, 0, 0, "R7 half merge");
    mem_acc(1, 32'h0500_0011, 3'd1, 32'h0000_005A, 0, "R7 byte write");
    mem_acc(0, 32'h0500_0010, 3'd4, 0, 0, "R7 byte merge");
    mem_acc(0, 32'h0500_0013, 3'd7, 0, 0, "R1 code 7 as word");
    mem_acc(0, 32'h0500_0011, 3'd2, 0, 0, "R1 S16 trimmed");
    // R2 / R3: mirrors
    mem_acc(0, 32'h05AB_0410, 3'd4, 0, 0, "R3 work RAM mirror");
    mem_acc(0, 32'hF500_0010, 3'd4, 0, 0, "R2 upper bits ignored");
    // R4: cartridge RAM
    mem_acc(1, 32'h0600_0020, 3'd4, 32'h1357_9BDF, 0, "R4 cart RAM write");
    mem_acc(0, 32'h0600_0420, 3'd4, 0, 0, "R4 cart RAM mirror");
    mem_acc(0, 32'h0600_0023, 3'd0, 0, 0, "R4 cart RAM S8");
    // R5: ROM write protection
    mem_acc(1, 32'h0700_0040, 3'd4, 32'hCAFE_F00D, 1, "R5 ROM debug write");
    mem_acc(0, 32'h0700_0040, 3'd4, 0, 0, "R5 ROM read");
    mem_acc(1, 32'h0700_0040, 3'd4, 32'h1111_2222, 0, "R5 ROM plain write");
    mem_acc(0, 32'h0700_0040, 3'd4, 0, 0, "R5 ROM unchanged");
    mem_acc(1, 32'h0700_0042, 3'd1, 32'h0000_0077, 1, "R5 ROM debug byte");
    mem_acc(0, 32'h0700_0040, 3'd4, 0, 0, "R5 ROM byte merged");
    // R6: empty and sound windows
    mem_acc(1, 32'h0300_0000, 3'd4, 32'hFFFF_FFFF, 0, "R6 empty write");
    mem_acc(0, 32'h0300_0000, 3'd4, 0, 0, "R6 empty read");
    mem_acc(1, 32'h0400_0100, 3'd4, 32'hFFFF_FFFF, 0, "R6 expansion write");
    mem_acc(0, 32'h0400_0100, 3'd0, 0, 0, "R6 expansion read");
    mem_acc(0, 32'h0100_0004, 3'd4, 0, 0, "R6 sound read");
    mem_acc(0, 32'h0500_0010, 3'd4, 0, 0, "R6 work RAM intact");
    // R10 / R8: port accesses
    port_acc(0, 32'h0000_1235, 3'd3, 0, 0, 2, 32'h1234_F0F1, "R8 video U16");
    port_acc(0, 32'h0000_1236, 3'd2, 0, 0, 1, 32'h1234_F0F1, "R8 video S16");
    port_acc(1, 32'h0200_0027, 3'd1, 32'h0000_00A5, 2, 0, 32'h0, "R10 misc write");
    port_acc(0, 32'hF200_0018, 3'd0, 0, 2, 3, 32'h0000_0080, "R2 misc S8");
    port_acc(1, 32'h0100_0403, 3'd5, 32'h0BAD_BEEF, 1, 1, 32'h0, "R10 sound write");
    port_acc(0, 32'h0000_0003, 3'd4, 0, 0, 0, 32'h8765_4321, "R1 video word");
    mem_acc(0, 32'h0500_0012, 3'd3, 0, 0, "R9 after port");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 all responses seen", q.size(), 0);
    finish_run();
  end

endmodule